// File: doc/BRIEF.md
# Floating-Point Control Register File

This block holds the single floating-point control and status word of a scalar core and presents it under several control register numbers. Number 31 exposes the whole 32-bit word. Numbers 25, 26 and 28 are narrow windows that repack selected fields of the same word, so software can read or change the condition codes, the exception flags, or the mode settings without a read-modify-write of the full word. Number 0 returns a fixed revision identifier.

A move-from-control read port returns the selected view combinationally. A move-to-control write port takes a register number and a 32-bit value. A write through a window changes only that window's fields and keeps every other bit. A separate update port from the arithmetic unit loads the condition codes and the cause field, and it ORs the cause bits into the sticky flags. A strap input enables the three windows. When the strap is low, the windows read as zero and writes to them do nothing.

Top module: `fpu_ctl_regs`

## Requirements
- R1: After reset the status word is zero, so reading register 31 returns 0.
- R2: Reading register 0 returns the parameter REV_ID. A write to register 0 leaves the status word unchanged.
- R3: A write to register 31 stores the written value with bits 20:18 forced to 0. Those bits always read as 0.
- R4: Reading register 25 returns status bit 23 in bit 0 and status bits 31:25 in bits 7:1. All other bits read as 0.
- R5: Writing register 25 loads status bit 23 from written bit 0 and status bits 31:25 from written bits 7:1. All other status bits are unchanged.
- R6: Reading register 28 returns flush-to-zero (status bit 24) in bit 2, the enables (bits 11:7) and the rounding mode (bits 1:0) in place, and 0 elsewhere. Writing register 28 replaces only those fields, with flush-to-zero taken from written bit 2.
- R7: Reading register 26 returns the cause field (bits 17:12) and the sticky flags (bits 6:2) in place, and 0 elsewhere. Writing register 26 replaces only those fields.
- R8: While views_en is low, registers 25, 26 and 28 read as 0 and writes to them leave the status word unchanged.
- R9: Any register number other than 0, 25, 26, 28 and 31 reads as 0, and writes to it leave the status word unchanged.
- R10: An arithmetic-unit update does three things. It loads au_cc[0] into bit 23 and au_cc[7:1] into bits 31:25. It loads au_cause into bits 17:12. It ORs au_cause[4:0] into the sticky bits 6:2.
- R11: A control write that takes effect in the same cycle as an arithmetic-unit update wins, and the update is dropped. A control write that is ignored lets the update through. A read in that cycle returns the value held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| views_en | input | 1 | Strap enabling registers 25, 26, 28 |
| rd_num | input | 5 | Read register number |
| rd_data | output | 32 | Read data (combinational) |
| wr_en | input | 1 | Control write strobe |
| wr_num | input | 5 | Write register number |
| wr_data | input | 32 | Write data |
| au_we | input | 1 | Arithmetic-unit update strobe |
| au_cc | input | 8 | New condition codes 7..0 |
| au_cause | input | 6 | New cause field |

## Verification
The hardest situation to create is a collision: a control write and an arithmetic-unit update arriving on the same edge, while the read port is sampled before that edge. The bench drives both strobes together in one cycle, checks the read data before the edge, and then checks that the control value alone was stored. It repeats the collision with a write to register 0. That write is ignored, so the update must land.

// File: rtl/fpu_ctl_regs.sv
module fpu_ctl_regs #(
  parameter logic [31:0] REV_ID = 32'h0001_0300,
  parameter int NUM_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             views_en,
  input  logic [NUM_W-1:0] rd_num,
  output logic [31:0]      rd_data,
  input  logic             wr_en,
  input  logic [NUM_W-1:0] wr_num,
  input  logic [31:0]      wr_data,
  input  logic             au_we,
  input  logic [7:0]       au_cc,
  input  logic [5:0]       au_cause
);
  localparam logic [NUM_W-1:0] N_REV  = NUM_W'(0);
  localparam logic [NUM_W-1:0] N_CC   = NUM_W'(25);
  localparam logic [NUM_W-1:0] N_FLG  = NUM_W'(26);
  localparam logic [NUM_W-1:0] N_MODE = NUM_W'(28);
  localparam logic [NUM_W-1:0] N_ALL  = NUM_W'(31);

  localparam logic [31:0] M_RSVD = 32'h001C_0000;
  localparam logic [31:0] M_CC   = 32'hFE80_0000;
  localparam logic [31:0] M_FLG  = 32'h0003_F07C;
  localparam logic [31:0] M_INPL = 32'h0000_0F83;
  localparam logic [31:0] M_MODE = 32'h0100_0F83;

  logic [31:0] stat, nxt_ctl, nxt_au;
  logic        ctl_hit;

  wire [31:0] v_cc   = {24'b0, stat[31:25], stat[23]};
  wire [31:0] v_flg  = stat & M_FLG;
  wire [31:0] v_mode = (stat & M_INPL) | {29'b0, stat[24], 2'b0};

  always_comb begin
    case (rd_num)
      N_REV:   rd_data = REV_ID;
      N_ALL:   rd_data = stat;
      N_CC:    rd_data = views_en ? v_cc : 32'b0;
      N_FLG:   rd_data = views_en ? v_flg : 32'b0;
      N_MODE:  rd_data = views_en ? v_mode : 32'b0;
      default: rd_data = 32'b0;
    endcase
  end

  always_comb begin
    ctl_hit = 1'b0;
    nxt_ctl = stat;
    if (wr_en) begin
      case (wr_num)
        N_ALL: begin
          ctl_hit = 1'b1;
          nxt_ctl = wr_data & ~M_RSVD;
        end
        N_CC: if (views_en) begin
          ctl_hit = 1'b1;
          nxt_ctl = (stat & ~M_CC) | {wr_data[7:1], 1'b0, wr_data[0], 23'b0};
        end
        N_FLG: if (views_en) begin
          ctl_hit = 1'b1;
          nxt_ctl = (stat & ~M_FLG) | (wr_data & M_FLG);
        end
        N_MODE: if (views_en) begin
          ctl_hit = 1'b1;
          nxt_ctl = (stat & ~M_MODE) | (wr_data & M_INPL) | {7'b0, wr_data[2], 24'b0};
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    nxt_au        = stat;
    nxt_au[31:25] = au_cc[7:1];
    nxt_au[23]    = au_cc[0];
    nxt_au[17:12] = au_cause;
    nxt_au[6:2]   = stat[6:2] | au_cause[4:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       stat <= 32'b0;
    else if (ctl_hit) stat <= nxt_ctl;
    else if (au_we)   stat <= nxt_au;
  end

  a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stat & M_RSVD) == 32'b0);

  a_r2_rev_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_num == N_REV && !au_we) |=> $stable(stat));

  a_r8_views_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !views_en && wr_num != N_ALL && !au_we) |=> $stable(stat));

  a_r8_views_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!views_en && (rd_num == N_CC || rd_num == N_FLG || rd_num == N_MODE)) |-> rd_data == 32'b0);

  a_r5_cc_keeps_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && views_en && wr_num == N_CC) |=> ((stat & ~M_CC) == ($past(stat) & ~M_CC)));

  a_r7_flg_keeps_rest: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && views_en && wr_num == N_FLG) |=> ((stat & ~M_FLG) == ($past(stat) & ~M_FLG)));

  a_r9_unimpl_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !au_we && wr_num != N_ALL && wr_num != N_CC && wr_num != N_FLG &&
     wr_num != N_MODE) |=> $stable(stat));

  a_r11_ctl_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_num == N_ALL) |=> stat == ($past(wr_data) & ~M_RSVD));
endmodule

// File: tb/test_fpu_ctl_regs.sv
module test_fpu_ctl_regs;
  localparam logic [31:0] REV = 32'h0001_0300;

  logic clk = 0, rst_n = 0, views_en = 1;
  logic [4:0] rd_num = 0, wr_num = 0;
  logic [31:0] rd_data, wr_data = 0;
  logic wr_en = 0, au_we = 0;
  logic [7:0] au_cc = 0;
  logic [5:0] au_cause = 0;
  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fpu_ctl_regs #(.REV_ID(REV)) i_fpu_ctl_regs (
    .clk(clk), .rst_n(rst_n), .views_en(views_en), .rd_num(rd_num), .rd_data(rd_data),
    .wr_en(wr_en), .wr_num(wr_num), .wr_data(wr_data),
    .au_we(au_we), .au_cc(au_cc), .au_cause(au_cause));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [4:0] n, input string req, input logic [31:0] exp);
    rd_num = n;
    #1;
    chk(req, rd_data, exp);
  endtask

  task automatic wr(input logic [4:0] n, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1; wr_num = n; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic t_reset;
    rd(31, "R1 reset word", 32'h0);
    rd(25, "R1 reset cc view", 32'h0);
  endtask

  task automatic t_rev;
    wr(31, 32'h0000_0003);
    rd(0, "R2 revision", REV);
    wr(0, 32'hFFFF_FFFF);
    rd(31, "R2 write ignored", 32'h0000_0003);
    rd(0, "R2 revision after write", REV);
  endtask

  task automatic t_full;
    wr(31, 32'hFFFF_FFFF);
    rd(31, "R3 reserved forced zero", 32'hFFE3_FFFF);
    wr(31, 32'h1234_5678);
    rd(31, "R3 pattern", 32'h1220_5678);
  endtask

  task automatic t_cc;
    wr(31, 32'h0);
    wr(25, 32'hFFFF_FF5A);
    rd(25, "R4 cc view", 32'h0000_005A);
    rd(31, "R5 cc into word", 32'h5A00_0000);
    wr(31, 32'h00FF_FFFF);
    rd(25, "R4 cc0 from bit23", 32'h0000_0001);
    wr(25, 32'h0000_0000);
    rd(31, "R5 others kept", 32'h0063_FFFF);
    wr(25, 32'h0000_0081);
    rd(31, "R5 cc7 and cc0", 32'h80E3_FFFF);
  endtask

  task automatic t_mode;
    wr(31, 32'h0);
    wr(28, 32'hFFFF_FFFF);
    rd(31, "R6 mode write", 32'h0100_0F83);
    rd(28, "R6 mode view", 32'h0000_0F87);
    wr(31, 32'hFFE3_FFFF);
    wr(28, 32'h0000_0000);
    rd(31, "R6 mode clears only its fields", 32'hFEE3_F07C);
  endtask

  task automatic t_flg;
    wr(31, 32'hFFE3_FFFF);
    rd(26, "R7 flag view", 32'h0003_F07C);
    wr(26, 32'h0);
    rd(31, "R7 flag clear", 32'hFFE0_0F83);
    wr(26, 32'hFFFF_FFFF);
    rd(31, "R7 flag set", 32'hFFE3_FFFF);
  endtask

  task automatic t_strap;
    wr(31, 32'hFFE3_FFFF);
    views_en = 0;
    rd(25, "R8 cc view gated", 32'h0);
    rd(26, "R8 flag view gated", 32'h0);
    rd(28, "R8 mode view gated", 32'h0);
    wr(28, 32'h0);
    wr(25, 32'h0);
    rd(31, "R8 writes ignored", 32'hFFE3_FFFF);
    views_en = 1;
  endtask

  task automatic t_unimpl;
    wr(31, 32'h0F0F_0F0F);
    rd(30, "R9 unimpl read", 32'h0);
    rd(1, "R9 unimpl read low", 32'h0);
    wr(30, 32'hFFFF_FFFF);
    wr(4, 32'h0);
    rd(31, "R9 unimpl write ignored", 32'h0F03_0F0F);
  endtask

  task automatic t_au;
    wr(31, 32'h0);
    @(negedge clk);
    au_we = 1; au_cc = 8'h81; au_cause = 6'h05;
    @(negedge clk);
    au_cc = 8'h00; au_cause = 6'h22;
    @(negedge clk);
    au_we = 0;
    rd(31, "R10 update and sticky accumulate", 32'h0002_201C);
  endtask

  task automatic t_collide;
    wr(31, 32'h0000_0055);
    @(negedge clk);
    wr_en = 1; wr_num = 31; wr_data = 32'h0000_00A5;
    au_we = 1; au_cc = 8'hFF; au_cause = 6'h3F;
    rd(31, "R11 read before edge", 32'h0000_0055);
    @(negedge clk);
    wr_en = 0; au_we = 0;
    rd(31, "R11 control write wins", 32'h0000_00A5);
    @(negedge clk);
    wr_en = 1; wr_num = 0; wr_data = 32'hFFFF_FFFF;
    au_we = 1; au_cc = 8'h01; au_cause = 6'h01;
    @(negedge clk);
    wr_en = 0; au_we = 0;
    rd(31, "R11 ignored write lets update in", 32'h0080_10A5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_rev;
    t_full;
    t_cc;
    t_mode;
    t_flg;
    t_strap;
    t_unimpl;
    t_au;
    t_collide;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule